// File: doc/BRIEF.md
# Serial Boot Memory Word Reader

This block fetches 16-bit words from an external nonvolatile boot memory through a slow serial port. The core raises a request with a word address. The block serialises that address onto a single output line, then pulses a latch strobe. After a short turnaround it shifts the returned word in on a single input line and hands the word back to the core with a one-cycle acknowledge.

Board logic outside the chip turns the address stream into parallel memory address lines. The same logic loads the memory's 16-bit output into a shift register that feeds the data line back. The serial clock is made by an internal divider, selectable from half the core clock down to one sixteenth of it. The divider setting is captured when a request is accepted and holds for that whole transfer.

A transfer lasts exactly 40 serial periods:
- periods 0 to 20 carry the address;
- period 21 carries the strobe;
- periods 22 and 23 are turnaround;
- periods 24 to 39 carry the data.

Top module: `boot_prom_reader`

## Requirements
- R1: After reset, `ready` is 1 and `ack_valid`, `sclk`, `sstrobe` and `saddr` are all 0. While idle, `sclk` stays 0.
- R2: With `div_sel` = N (0 to 7), every serial period lasts 2(N+1) core cycles. `sclk` is low for the first N+1 cycles of each period and high for the last N+1.
- R3: The 21-bit word address goes out on `saddr` MSB first, one bit per serial period in periods 0 to 20. Each bit is stable across the rising edge of `sclk` in its period.
- R4: `sstrobe` is 1 for exactly serial period 21, and it is 0 at every other rising edge of `sclk`.
- R5: The level on `sdata` during periods 21 to 23 (strobe and the two turnaround periods) has no effect on the returned word.
- R6: `sdata` is sampled on the rising `sclk` edge of periods 24 to 39. The first sample is bit 15 of the word and the last is bit 0.
- R7: `ack_valid` is 1 for exactly one core cycle, appearing 40·2(N+1) core cycles after the accepting clock edge. In that cycle `ack_data` holds the assembled word.
- R8: A request is accepted only when `ready` is 1. `ready` is 0 from the cycle after acceptance until the acknowledge. A `req_valid` raised while busy changes neither the address sent nor the number of acknowledges.
- R9: `div_sel` is sampled only at acceptance. Changing it during a transfer does not alter that transfer's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request |
| req_addr | input | 21 | Word address of the request |
| div_sel | input | 3 | Serial clock divider code N, period 2(N+1) core cycles |
| ready | output | 1 | Block idle, request may be accepted |
| ack_valid | output | 1 | One-cycle pulse with returned word |
| ack_data | output | 16 | Returned word |
| sclk | output | 1 | Serial clock to board logic |
| saddr | output | 1 | Serial address bit |
| sstrobe | output | 1 | Address latch strobe |
| sdata | input | 1 | Serial data bit from board logic |

## Verification
The assertions assume that `sdata` comes from board logic that changes only while `sclk` is low. They also assume the core treats `ready` as the sole gate for acceptance. Nothing is assumed about `req_valid` while busy, and the bench deliberately pulses it mid-transfer.

The bench plays the board logic. It shifts `saddr` in on rising `sclk` edges and drives each data bit right after a falling edge. It puts deliberate junk on `sdata` during the strobe and turnaround periods. Every divider code is swept against several address patterns, so all stimulus stays inside those assumptions.

// File: rtl/prom_rd_pkg.sv
package prom_rd_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} prom_state_t;
endpackage

// File: rtl/prom_sclk_gen.sv
module prom_sclk_gen #(
  parameter int HALF_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [HALF_W-1:0] half,
  output logic              rise_tick,
  output logic              fall_tick,
  output logic              sclk
);
  localparam int CW = HALF_W + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] half_ext;

  assign half_ext  = CW'(half);
  assign rise_tick = en && (cnt == half_ext - CW'(1));
  assign fall_tick = en && (cnt == (half_ext << 1) - CW'(1));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else begin
      cnt <= fall_tick ? '0 : cnt + CW'(1);
      if (rise_tick)      sclk <= 1'b1;
      else if (fall_tick) sclk <= 1'b0;
    end
  end
endmodule

// File: rtl/prom_addr_tx.sv
module prom_addr_tx #(
  parameter int AW = 21
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] addr,
  input  logic          shift,
  output logic          sbit
);
  logic [AW-1:0] sr;

  assign sbit = sr[AW-1];

  always_ff @(posedge clk) begin
    if (rst)        sr <= '0;
    else if (load)  sr <= addr;
    else if (shift) sr <= {sr[AW-2:0], 1'b0};
  end
endmodule

// File: rtl/prom_data_rx.sv
module prom_data_rx #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          sample,
  input  logic          din,
  output logic [DW-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst || clear) word <= '0;
    else if (sample)  word <= {word[DW-2:0], din};
  end
endmodule

// File: rtl/boot_prom_reader.sv
module boot_prom_reader
  import prom_rd_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int DATA_W   = 16,
  parameter int DIV_W    = 3,
  parameter int TURN_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DIV_W-1:0]  div_sel,
  output logic              ready,
  output logic              ack_valid,
  output logic [DATA_W-1:0] ack_data,
  output logic              sclk,
  output logic              saddr,
  output logic              sstrobe,
  input  logic              sdata
);
  localparam int STRB_IDX   = ADDR_W;
  localparam int DATA_START = ADDR_W + 1 + TURN_CYC;
  localparam int LAST_IDX   = DATA_START + DATA_W - 1;
  localparam int CNT_W      = $clog2(LAST_IDX + 1);
  localparam int HALF_W     = DIV_W + 1;

  prom_state_t       state;
  logic [CNT_W-1:0]  bidx;
  logic [HALF_W-1:0] half_q;
  logic              rise_tick, fall_tick;
  logic [DATA_W-1:0] word;
  logic              busy, accept;

  assign busy   = (state == ST_BUSY);
  assign accept = req_valid && (state == ST_IDLE);
  assign ready  = (state == ST_IDLE);

  prom_sclk_gen #(.HALF_W(HALF_W)) u_sclk (
    .clk(clk), .rst(rst), .en(busy), .half(half_q),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .sclk(sclk)
  );

  prom_addr_tx #(.AW(ADDR_W)) u_atx (
    .clk(clk), .rst(rst), .load(accept), .addr(req_addr),
    .shift(fall_tick), .sbit(saddr)
  );

  prom_data_rx #(.DW(DATA_W)) u_drx (
    .clk(clk), .rst(rst), .clear(accept),
    .sample(rise_tick && (bidx >= CNT_W'(DATA_START))),
    .din(sdata), .word(word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bidx      <= '0;
      half_q    <= HALF_W'(1);
      sstrobe   <= 1'b0;
      ack_valid <= 1'b0;
      ack_data  <= '0;
    end else begin
      ack_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            state   <= ST_BUSY;
            bidx    <= '0;
            half_q  <= HALF_W'(div_sel) + HALF_W'(1);
            sstrobe <= 1'b0;
          end
        end
        ST_BUSY: begin
          if (fall_tick) begin
            if (bidx == CNT_W'(LAST_IDX)) begin
              state     <= ST_IDLE;
              ack_valid <= 1'b1;
              ack_data  <= word;
              sstrobe   <= 1'b0;
            end else begin
              bidx    <= bidx + CNT_W'(1);
              sstrobe <= (bidx + CNT_W'(1) == CNT_W'(STRB_IDX));
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/prom_rd_chk.sv
module prom_rd_chk #(
  parameter int DIV_W = 3
) (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic ready,
  input logic ack_valid,
  input logic sclk,
  input logic sstrobe
);
  localparam int MAXH = 1 << DIV_W;
  localparam int RW   = DIV_W + 2;

  logic [RW-1:0] hi_run;

  always_ff @(posedge clk) begin
    if (rst || !sclk) hi_run <= '0;
    else if (hi_run != {RW{1'b1}}) hi_run <= hi_run + RW'(1);
  end

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    ack_valid |=> !ack_valid); // R7
  AST_ACK_IDLE: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> ready); // R7
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ready) |=> !ready); // R8
  AST_IDLE_SCLK_LOW: assert property (@(posedge clk) disable iff (rst)
    ready |-> !sclk); // R1
  AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (rst)
    sstrobe |-> !ready); // R4
  AST_STROBE_AT_FALL: assert property (@(posedge clk) disable iff (rst)
    $rose(sstrobe) |-> !sclk); // R4
  AST_HIGH_BOUND: assert property (@(posedge clk) disable iff (rst)
    hi_run <= RW'(MAXH)); // R2
endmodule

bind boot_prom_reader prom_rd_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .ready(ready),
  .ack_valid(ack_valid), .sclk(sclk), .sstrobe(sstrobe)
);

// File: tb/tb_boot_prom_reader.sv
`timescale 1ns/1ps
module tb_boot_prom_reader;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [20:0] req_addr = '0;
  logic [2:0]  div_sel = '0;
  logic        ready, ack_valid, sclk, saddr, sstrobe;
  logic [15:0] ack_data;
  logic        sdata = 1'b0;

  int n_chk = 0, n_bad = 0, cyc = 0, acks = 0;
  bit active = 0, done = 0;
  int rise_n = 0, fall_n = 0, strobe_err = 0, hi_err = 0, exp_half = 1;
  logic [20:0] addr_cap;
  logic [15:0] exp_word;
  time rise_t;

  boot_prom_reader dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .div_sel(div_sel), .ready(ready), .ack_valid(ack_valid),
    .ack_data(ack_data), .sclk(sclk), .saddr(saddr), .sstrobe(sstrobe),
    .sdata(sdata)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (ack_valid) acks++;

  function automatic logic [15:0] memf(input logic [20:0] a);
    logic [15:0] m;
    m = a[15:0] * 16'h9E37;
    return m ^ {6'b0, a[20:16], 5'h0};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // board logic model: shift address in, return word serially
  always @(posedge sclk) if (active) begin
    rise_t = $time;
    if (rise_n < 21) addr_cap = {addr_cap[19:0], saddr};
    if (rise_n == 21) begin
      if (sstrobe !== 1'b1) strobe_err++;
      exp_word = memf(addr_cap);
    end else if (sstrobe !== 1'b0) strobe_err++;
    rise_n++;
  end

  always @(negedge sclk) if (active) begin
    if (($time - rise_t) != exp_half * 4) hi_err++;
    if (fall_n >= 23 && fall_n <= 38) sdata = exp_word[38 - fall_n];
    else if (fall_n == 20 || fall_n == 21 || fall_n == 22) sdata = fall_n[0]; // junk for R5
    else sdata = 1'b0;
    fall_n++;
  end

  task automatic do_read(input logic [20:0] a, input int div, input bit disturb);
    int t0, wait_n;
    logic [15:0] got;
    int ack0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; div_sel = 3'(div);
    rise_n = 0; fall_n = 0; strobe_err = 0; hi_err = 0;
    exp_half = div + 1; addr_cap = '0; exp_word = '0; active = 1;
    ack0 = acks;
    @(negedge clk);
    t0 = cyc;
    req_valid = 1'b0;
    check("R8 ready low after accept", {31'b0, ready}, 0);
    if (disturb) begin
      div_sel = 3'(7 - div); // R9: change mid-transfer
      repeat (5) @(negedge clk);
      req_valid = 1'b1; req_addr = ~a;  // R8: request while busy
      @(negedge clk);
      req_valid = 1'b0;
    end
    wait_n = 0;
    while (!ack_valid && wait_n < 2000) begin
      @(negedge clk); wait_n++;
    end
    if (!ack_valid) begin
      check("R7 ack timeout", 0, 1);
    end else begin
      got = ack_data;
      check("R7 latency", 32'(cyc - t0), 32'(40 * 2 * (div + 1)));
      check("R3 address shifted out", {11'b0, addr_cap}, {11'b0, a});
      check("R4 strobe only in period 21", 32'(strobe_err), 0);
      check("R2 sclk high width", 32'(hi_err), 0);
      check("R6 R5 word returned", {16'b0, got}, {16'b0, memf(a)});
      check("R7 ready with ack", {31'b0, ready}, 1);
      @(negedge clk);
      check("R7 ack one cycle", {31'b0, ack_valid}, 0);
      check("R1 sclk low idle", {31'b0, sclk}, 0);
      if (disturb) check("R8 single ack", 32'(acks - ack0), 1);
    end
    active = 0;
    sdata = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ready", {31'b0, ready}, 1);
    check("R1 ack_valid", {31'b0, ack_valid}, 0);
    check("R1 sclk", {31'b0, sclk}, 0);
    check("R1 sstrobe", {31'b0, sstrobe}, 0);
    check("R1 saddr", {31'b0, saddr}, 0);
    for (int d = 0; d < 8; d++) begin
      do_read(21'h000000, d, 0);
      do_read(21'h1FFFFF, d, 0);
      do_read(21'h155555, d, 0);
      do_read(21'h0AAAAA, d, 0);
      do_read(21'(32'h12345 * (d + 3)), d, 0);
    end
    do_read(21'h0F0F0F, 0, 1);
    do_read(21'h13579B, 7, 1);
    do_read(21'h02468A, 3, 1);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule